// File: doc/BRIEF.md
# Smart Wake-Up Controller

This block sequences a low-power radio's periodic wake-ups. A slow clock, taken from either of two synchronized enable inputs, feeds a prescaler that divides by a power of two. A 16-bit down-counting timer runs on the divided pulse. Each time the timer expires it raises a timeout flag, bumps a 16-bit wake counter and compares the new count with a programmable threshold. All logic runs on one fast system clock.

When listening is enabled, each expiry also opens a receive window. While the window is open the block requests signal-strength samples. A sample strictly above a programmable level raises a detect flag and closes the window. If no such sample arrives before a programmable dwell count runs out, the window closes and the block goes back to sleep. Every flag is a sticky level that a write-one-to-clear register resets. Each interrupt output is the flag gated by its own mask bit.

Software programs the block through a byte-wide write port. The timer reload value is written in two steps: the high byte is staged first, and the low byte commits both bytes.

Top module: `smart_wake_ctrl`

## Requirements
- R1: The timer steps once for every 2^N pulses of the selected slow source. N is in config bits 4:2 (address 0). Config bit 1 selects the source: 0 is the RC tick, 1 is the crystal tick. Pulses on the unselected source are ignored, and no step occurs while config bit 0 (timer enable) is 0.
- R2: After a reload commit, the timer raises its timeout flag on the (reload+1)-th step and then reloads itself, so each later period is also reload+1 steps.
- R3: A write to address 1 only stages the high byte and changes nothing else. A write to address 2 commits {staged high, written low} as the reload value and restarts the timer. A write to address 2 with no address-1 write since the last commit is ignored.
- R4: Each timeout adds one to the wake counter. The wake flag is set when the new count is strictly greater than the threshold, whose low byte is at address 3 and high byte at address 4.
- R5: With config bit 5 set, a timeout opens a listen window and listen_o goes high. A timeout that occurs while a window is open neither restarts nor extends that window.
- R6: Inside a window, an rssi_valid_i sample with a value strictly above the level at address 6 sets the detect flag and closes the window at the next edge. A value equal to the level has no effect.
- R7: Without a detection, the window stays open for exactly dwell+1 cycles, where dwell is the value at address 7. A qualifying sample in the last cycle still sets the detect flag. A sample arriving after the window has closed is ignored.
- R8: The mask at address 5 gates the outputs: bit 0 gates the timeout interrupt, bit 1 the wake interrupt and bit 2 the detect interrupt. A flag stays set while masked and appears on its output once it is unmasked.
- R9: Writing a 1 to a bit of address 8 clears the flag in the same bit position. Bit 1 also resets the wake counter to zero.
- R10: After reset all interrupt outputs and listen_o are low, every register is zero and no reload value is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_tick_i | input | 1 | Synchronized one-cycle pulse from the RC slow clock |
| xtal_tick_i | input | 1 | Synchronized one-cycle pulse from the crystal slow clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| rssi_valid_i | input | 1 | Signal-strength sample valid |
| rssi_value_i | input | 8 | Signal-strength sample |
| listen_o | output | 1 | Listen window open; this is also the measurement request |
| irq_timeout_o | output | 1 | Masked timer-timeout interrupt |
| irq_wake_o | output | 1 | Masked wake-count interrupt |
| irq_detect_o | output | 1 | Masked signal-detect interrupt |

## Verification
Two decisions can land in the same cycle: a detection and the expiry of the dwell count. The bench provokes this by sending a qualifying sample in the final open cycle of a window. It then expects the detect flag to be set and the window to be closed one edge later. A second case sends the same sample one cycle later, after the window has closed, and expects no detect flag. A third case fires a second timeout while a window is open and requires the window to keep its original length.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int TMR_W   = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int RSSI_W  = 8;
  localparam int PRE_W   = 3;
  localparam int NUM_IRQ = 3;

  localparam int IRQ_TMO  = 0;
  localparam int IRQ_WAKE = 1;
  localparam int IRQ_DET  = 2;

  localparam logic [ADDR_W-1:0] A_CFG      = 4'd0;
  localparam logic [ADDR_W-1:0] A_RLD_HI   = 4'd1;
  localparam logic [ADDR_W-1:0] A_RLD_LO   = 4'd2;
  localparam logic [ADDR_W-1:0] A_THR_LO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_THR_HI   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK     = 4'd5;
  localparam logic [ADDR_W-1:0] A_RSSI_THR = 4'd6;
  localparam logic [ADDR_W-1:0] A_DWELL    = 4'd7;
  localparam logic [ADDR_W-1:0] A_CLR      = 4'd8;

  // bit order matches config byte bits 5..0
  typedef struct packed {
    logic             listen_en;
    logic [PRE_W-1:0] pre_n;
    logic             src_xtal;
    logic             timer_en;
  } cfg_t;

  typedef enum logic {ST_SLEEP = 1'b0, ST_LISTEN = 1'b1} lst_t;
endpackage

// File: rtl/swc_regs.sv
module swc_regs
  import swc_pkg::*;
#(
  parameter int DWELL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output cfg_t                 cfg_o,
  output logic [TMR_W-1:0]     reload_o,
  output logic                 load_o,
  output logic [TMR_W-1:0]     wthr_o,
  output logic [NUM_IRQ-1:0]   mask_o,
  output logic [RSSI_W-1:0]    rssi_thr_o,
  output logic [DWELL_W-1:0]   dwell_o,
  output logic [NUM_IRQ-1:0]   clr_o
);
  localparam int CFG_W = $bits(cfg_t);

  logic [DATA_W-1:0] hi_stage_q;
  logic              hi_pend_q;
  logic              commit;

  assign commit = we_i && (addr_i == A_RLD_LO) && hi_pend_q;
  assign clr_o  = (we_i && (addr_i == A_CLR)) ? wdata_i[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o      <= '0;
      hi_stage_q <= '0;
      hi_pend_q  <= 1'b0;
      reload_o   <= '0;
      load_o     <= 1'b0;
      wthr_o     <= '0;
      mask_o     <= '0;
      rssi_thr_o <= '0;
      dwell_o    <= '0;
    end else begin
      load_o <= commit;
      if (commit) begin
        reload_o  <= {hi_stage_q, wdata_i};
        hi_pend_q <= 1'b0;
      end
      if (we_i) begin
        unique case (addr_i)
          A_CFG:      cfg_o <= cfg_t'(wdata_i[CFG_W-1:0]);
          A_RLD_HI: begin
            hi_stage_q <= wdata_i;
            hi_pend_q  <= 1'b1;
          end
          A_THR_LO:   wthr_o[DATA_W-1:0]     <= wdata_i;
          A_THR_HI:   wthr_o[TMR_W-1:DATA_W] <= wdata_i;
          A_MASK:     mask_o     <= wdata_i[NUM_IRQ-1:0];
          A_RSSI_THR: rssi_thr_o <= wdata_i[RSSI_W-1:0];
          A_DWELL:    dwell_o    <= DWELL_W'(wdata_i);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/swc_prescaler.sv
module swc_prescaler
  import swc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_xtal_i,
  input  logic             rc_tick_i,
  input  logic             xtal_tick_i,
  input  logic [PRE_W-1:0] pre_n_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] limit;
  logic             src_tick;

  assign src_tick = src_xtal_i ? xtal_tick_i : rc_tick_i;
  assign span     = ({{DIV_W{1'b0}}, 1'b1} << pre_n_i) - 1'b1;
  assign limit    = span[DIV_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (src_tick) begin
        if (cnt_q >= limit) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swc_wake_timer.sv
module swc_wake_timer
  import swc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] wthr_i,
  input  logic             cnt_clr_i,
  output logic             timeout_o,
  output logic             wake_hit_o,
  output logic [TMR_W-1:0] wake_cnt_o
);
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] wake_base;
  logic [TMR_W-1:0] wake_nx;

  assign timeout_o  = en_i && tick_i && !load_i && (tmr_q == '0);
  assign wake_base  = cnt_clr_i ? '0 : wake_cnt_o;
  assign wake_nx    = wake_base + 1'b1;
  assign wake_hit_o = timeout_o && (wake_nx > wthr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else if (load_i) begin
      tmr_q <= reload_i;
    end else if (en_i && tick_i) begin
      tmr_q <= (tmr_q == '0) ? reload_i : tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_cnt_o <= '0;
    end else if (timeout_o) begin
      wake_cnt_o <= wake_nx;
    end else if (cnt_clr_i) begin
      wake_cnt_o <= '0;
    end
  end
endmodule

// File: rtl/swc_listen.sv
module swc_listen
  import swc_pkg::*;
#(
  parameter int DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               listen_en_i,
  input  logic               timeout_i,
  input  logic               rssi_valid_i,
  input  logic [RSSI_W-1:0]  rssi_val_i,
  input  logic [RSSI_W-1:0]  rssi_thr_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               listen_o,
  output logic               detect_o
);
  lst_t               st_q;
  logic [DWELL_W-1:0] left_q;

  assign listen_o = (st_q == ST_LISTEN);
  assign detect_o = listen_o && rssi_valid_i && (rssi_val_i > rssi_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SLEEP;
      left_q <= '0;
    end else begin
      unique case (st_q)
        ST_SLEEP: if (timeout_i && listen_en_i) begin
          st_q   <= ST_LISTEN;
          left_q <= dwell_i;
        end
        ST_LISTEN: begin
          // detection takes priority over dwell expiry
          if (detect_o || left_q == '0) st_q <= ST_SLEEP;
          else left_q <= left_q - 1'b1;
        end
        default: st_q <= ST_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/swc_irq.sv
module swc_irq
  import swc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= set_i[g] || (flag_q && !clr_i[g]);
    end
    assign irq_o[g] = flag_q && mask_i[g];
  end
endmodule

// File: rtl/smart_wake_ctrl.sv
module smart_wake_ctrl
  import swc_pkg::*;
#(
  parameter int DWELL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rc_tick_i,
  input  logic                 xtal_tick_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  input  logic                 rssi_valid_i,
  input  logic [RSSI_W-1:0]    rssi_value_i,
  output logic                 listen_o,
  output logic                 irq_timeout_o,
  output logic                 irq_wake_o,
  output logic                 irq_detect_o
);
  cfg_t               cfg;
  logic [TMR_W-1:0]   reload;
  logic               load;
  logic [TMR_W-1:0]   wthr;
  logic [NUM_IRQ-1:0] mask;
  logic [RSSI_W-1:0]  rssi_thr;
  logic [DWELL_W-1:0] dwell;
  logic [NUM_IRQ-1:0] clr;
  logic               pre_tick;
  logic               tmo_evt;
  logic               wake_hit;
  logic [TMR_W-1:0]   wake_cnt;
  logic               detect;
  logic [NUM_IRQ-1:0] set_vec;
  logic [NUM_IRQ-1:0] irq_vec;

  swc_regs #(.DWELL_W(DWELL_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cfg_o(cfg), .reload_o(reload), .load_o(load), .wthr_o(wthr),
    .mask_o(mask), .rssi_thr_o(rssi_thr), .dwell_o(dwell), .clr_o(clr)
  );

  swc_prescaler pre_i (
    .clk_i, .rst_ni,
    .en_i(cfg.timer_en), .src_xtal_i(cfg.src_xtal),
    .rc_tick_i, .xtal_tick_i, .pre_n_i(cfg.pre_n), .tick_o(pre_tick)
  );

  swc_wake_timer tmr_i (
    .clk_i, .rst_ni,
    .en_i(cfg.timer_en), .load_i(load), .reload_i(reload), .tick_i(pre_tick),
    .wthr_i(wthr), .cnt_clr_i(clr[IRQ_WAKE]),
    .timeout_o(tmo_evt), .wake_hit_o(wake_hit), .wake_cnt_o(wake_cnt)
  );

  swc_listen #(.DWELL_W(DWELL_W)) lst_i (
    .clk_i, .rst_ni,
    .listen_en_i(cfg.listen_en), .timeout_i(tmo_evt),
    .rssi_valid_i, .rssi_val_i(rssi_value_i), .rssi_thr_i(rssi_thr),
    .dwell_i(dwell), .listen_o, .detect_o(detect)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[IRQ_TMO]  = tmo_evt;
    set_vec[IRQ_WAKE] = wake_hit;
    set_vec[IRQ_DET]  = detect;
  end

  swc_irq irq_i (
    .clk_i, .rst_ni,
    .set_i(set_vec), .clr_i(clr), .mask_i(mask), .irq_o(irq_vec)
  );

  assign irq_timeout_o = irq_vec[IRQ_TMO];
  assign irq_wake_o    = irq_vec[IRQ_WAKE];
  assign irq_detect_o  = irq_vec[IRQ_DET];
endmodule

// File: rtl/smart_wake_ctrl_chk.sv
module smart_wake_ctrl_chk
  import swc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmo_evt,
  input logic              listen_en,
  input logic              listen_o,
  input logic              detect,
  input logic              wake_clr,
  input logic [TMR_W-1:0]  wake_cnt,
  input logic [TMR_W-1:0]  reload,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_timeout_o
);
  assert_stage_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_RLD_HI) |=> $stable(reload));

  assert_wake_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_evt && !wake_clr) |=> (wake_cnt == $past(wake_cnt) + 1'b1));

  assert_listen_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(listen_o) |-> $past(tmo_evt && listen_en));

  assert_detect_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect |=> !listen_o);

  assert_clear_tmo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CLR && reg_wdata_i[IRQ_TMO] && !tmo_evt)
      |=> !irq_timeout_o);
endmodule

bind smart_wake_ctrl smart_wake_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tmo_evt(tmo_evt), .listen_en(cfg.listen_en),
  .listen_o(listen_o), .detect(detect), .wake_clr(clr[IRQ_WAKE]),
  .wake_cnt(wake_cnt), .reload(reload), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .irq_timeout_o(irq_timeout_o)
);

// File: tb/smart_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module smart_wake_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rc = 1'b0, xt = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       rv = 1'b0;
  logic [7:0] rval = '0;
  logic       listen, i_tmo, i_wake, i_det;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  smart_wake_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rc_tick_i(rc), .xtal_tick_i(xt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .rssi_valid_i(rv), .rssi_value_i(rval),
    .listen_o(listen), .irq_timeout_o(i_tmo), .irq_wake_o(i_wake), .irq_detect_o(i_det)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rc_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rc = 1'b1;
      @(negedge clk); rc = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic xt_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xt = 1'b1;
      @(negedge clk); xt = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic commit_reload(input logic [15:0] v);
    wr(4'd1, v[15:8]);
    wr(4'd2, v[7:0]);
  endtask

  // start a window with one RC pulse; returns at the first negedge with listen high
  task automatic open_window();
    @(negedge clk); rc = 1'b1;
    @(negedge clk); rc = 1'b0;
    for (int i = 0; i < 10 && !listen; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10", "irq_timeout", i_tmo, 0);
    check("R10", "irq_wake", i_wake, 0);
    check("R10", "irq_detect", i_det, 0);
    check("R10", "listen", listen, 0);
  endtask

  task automatic t_split_reload();
    wr(4'd5, 8'h07);
    wr(4'd3, 8'h01); wr(4'd4, 8'h00);
    commit_reload(16'd2);
    wr(4'd0, 8'h01);
    rc_pulse(2);
    check("R2", "no timeout before reload+1", i_tmo, 0);
    rc_pulse(1);
    check("R2", "timeout on reload+1", i_tmo, 1);
    check("R4", "count 1 not above 1", i_wake, 0);
    wr(4'd8, 8'h01);
    check("R9", "timeout cleared", i_tmo, 0);
    rc_pulse(3);
    check("R2", "second period", i_tmo, 1);
    check("R4", "count 2 above 1", i_wake, 1);
  endtask

  task automatic t_lo_only();
    wr(4'd8, 8'h07);
    check("R9", "wake cleared", i_wake, 0);
    wr(4'd2, 8'h00);
    rc_pulse(2);
    check("R3", "lone low write ignored", i_tmo, 0);
    rc_pulse(1);
    check("R3", "old reload kept", i_tmo, 1);
    check("R9", "counter zeroed by clear", i_wake, 0);
  endtask

  task automatic t_source();
    wr(4'd8, 8'h07);
    commit_reload(16'd0);
    wr(4'd0, 8'h03);
    rc_pulse(3);
    check("R1", "rc ignored with xtal source", i_tmo, 0);
    xt_pulse(1);
    check("R1", "xtal tick counted", i_tmo, 1);
  endtask

  task automatic t_prescale();
    wr(4'd8, 8'h07);
    wr(4'd0, 8'h09);
    commit_reload(16'd0);
    rc_pulse(3);
    check("R1", "div4 three ticks", i_tmo, 0);
    rc_pulse(1);
    check("R1", "div4 fourth tick", i_tmo, 1);
    wr(4'd8, 8'h07);
    wr(4'd0, 8'h08);
    rc_pulse(8);
    check("R1", "disabled timer", i_tmo, 0);
  endtask

  task automatic t_mask();
    wr(4'd5, 8'h06);
    wr(4'd0, 8'h01);
    wr(4'd8, 8'h07);
    rc_pulse(1);
    check("R8", "masked timeout", i_tmo, 0);
    wr(4'd5, 8'h07);
    check("R8", "pending shown on unmask", i_tmo, 1);
    wr(4'd8, 8'h01);
    check("R9", "w1c timeout", i_tmo, 0);
  endtask

  task automatic t_detect();
    wr(4'd8, 8'h07);
    wr(4'd6, 8'h40);
    wr(4'd7, 8'd20);
    wr(4'd0, 8'h21);
    rc_pulse(1);
    check("R5", "window open", listen, 1);
    @(negedge clk); rv = 1'b1; rval = 8'h40;
    @(negedge clk); rv = 1'b0;
    check("R6", "equal value no detect", i_det, 0);
    check("R6", "window still open", listen, 1);
    rval = 8'h41; rv = 1'b1;
    @(negedge clk); rv = 1'b0;
    check("R6", "detect raised", i_det, 1);
    check("R6", "window closed", listen, 0);
  endtask

  task automatic t_dwell();
    int len = 0;
    wr(4'd8, 8'h07);
    wr(4'd7, 8'd5);
    @(negedge clk); rc = 1'b1;
    @(negedge clk); rc = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (listen) len++;
    end
    check("R7", "window length dwell+1", len, 6);
    check("R7", "no detect without sample", i_det, 0);
  endtask

  task automatic t_last_cycle();
    wr(4'd8, 8'h04);
    open_window();
    repeat (5) @(negedge clk);
    rv = 1'b1; rval = 8'h7f;
    @(negedge clk); rv = 1'b0;
    check("R7", "detect on last dwell cycle", i_det, 1);
    check("R7", "closed after last cycle", listen, 0);
    repeat (3) @(negedge clk);
    wr(4'd8, 8'h04);
    open_window();
    repeat (6) @(negedge clk);
    rv = 1'b1; rval = 8'h7f;
    @(negedge clk); rv = 1'b0;
    check("R7", "sample after window ignored", i_det, 0);
  endtask

  task automatic t_retrigger();
    int len = 0;
    wr(4'd8, 8'h07);
    wr(4'd7, 8'd10);
    open_window();
    repeat (2) @(negedge clk);
    rc = 1'b1;
    @(negedge clk); rc = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (listen) len++;
    end
    check("R5", "timeout in window keeps length", len, 7);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_split_reload();
    t_lo_only();
    t_source();
    t_prescale();
    t_mask();
    t_detect();
    t_dwell();
    t_last_cycle();
    t_retrigger();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule